// File: doc/BRIEF.md
# Calibration Trigger Arbiter

This block sits in the central level-0 trigger logic and turns calibration requests from detector subsystems into delayed trigger words. Each subsystem raises its request line when it pulses its own calibration system. The arbiter looks for the rising edge of each line. It keeps only the requests that the current beam phase permits and picks at most one winner per cycle. The winner is sent down a shift pipeline, so the trigger comes out a fixed, programmable number of cycles later, tagged with its type and the source that caused it.

The beam phase comes from a level input that goes high once the beam has really ended. Two separate enable masks are used: one while the beam is on (in-burst) and one once it has ended (out-of-burst). On the cycle where the end-of-beam level first rises, the arbiter inserts a control trigger of its own. Subsystems use it, for example, to change their pulser settings. That control trigger beats any calibration request in the same cycle. Requests that were permitted but lost the slot are added to a saturating refusal counter.

Top module: `calib_trig_arbiter`

## Requirements
- R1: While reset is held and after it is released, `trig_valid_o` is 0, `trig_type_o` is 2'b00 and `refused_cnt_o` is 0. A trigger still in flight when reset is asserted never appears.
- R2: A request counts only on a rising edge of its `req_i` bit. A bit held high for many cycles yields exactly one trigger.
- R3: While `end_of_beam_i` is 0, a request from source i is eligible only if `mask_in_burst_i[i]` is 1.
- R4: While `end_of_beam_i` is 1, a request from source i is eligible only if `mask_out_burst_i[i]` is 1.
- R5: When several eligible requests arrive in one cycle, the lowest-numbered source wins and the others are refused.
- R6: A trigger decided from inputs sampled at clock edge k is shown on the outputs for one cycle, right after edge k+D-1. D equals `delay_i` for values 1 to 16. A value of 0 acts as 1, and values above 16 act as 16.
- R7: On the first sampled cycle where `end_of_beam_i` is 1 after being 0, a control trigger is issued. All eligible calibration requests in that cycle are refused. No further control trigger is issued while the level stays high.
- R8: `refused_cnt_o` grows by the number of eligible requests that did not win their cycle. Masked requests are not counted, and the counter saturates at all-ones.
- R9: Output encoding: `trig_type_o` is 2'b00 when `trig_valid_o` is 0. It is 2'b01 for a calibration trigger, with `trig_src_o` holding the source index. It is 2'b10 for a control trigger, with `trig_src_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_SRC | Calibration request line per source |
| end_of_beam_i | input | 1 | High once the beam has really ended (out-of-burst) |
| mask_in_burst_i | input | NUM_SRC | Per-source enable while in-burst |
| mask_out_burst_i | input | NUM_SRC | Per-source enable while out-of-burst |
| delay_i | input | DLY_W | Trigger delay in cycles (clamped to 1..MAX_DELAY) |
| trig_valid_o | output | 1 | Trigger present this cycle |
| trig_type_o | output | 2 | 00 none, 01 calibration, 10 control |
| trig_src_o | output | SRC_W | Source index of a calibration trigger |
| refused_cnt_o | output | CNT_W | Saturating count of refused eligible requests |

## Verification
Two things can claim the single entry slot in the same cycle: the self-generated control trigger and a calibration request. The bench raises `end_of_beam_i` in the same cycle as a request that the out-of-burst mask permits. It then checks that only a control trigger (type 2'b10, source 0) comes out after the delay, and that the refusal counter goes up by one. It also repeats the case with a request that the mask blocks, and checks that the counter stays unchanged. The two cases differ only in whether the loser was eligible.

// File: rtl/cta_pkg.sv
`timescale 1ns/1ps
package cta_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'b00,
    TRIG_CALIB = 2'b01,
    TRIG_CTRL  = 2'b10
  } trig_kind_e;

endpackage

// File: rtl/cta_req_capture.sv
`timescale 1ns/1ps
module cta_req_capture #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               eob_i,
  input  logic [NUM_SRC-1:0] mask_in_i,
  input  logic [NUM_SRC-1:0] mask_out_i,
  output logic [NUM_SRC-1:0] cand_o,
  output logic               eob_rise_o
);

  logic [NUM_SRC-1:0] req_prev_q, req_prev_d;
  logic               eob_prev_q, eob_prev_d;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] phase_mask;

  always_comb begin
    req_prev_d = req_i;
    eob_prev_d = eob_i;
    rise       = req_i & ~req_prev_q;
    phase_mask = eob_i ? mask_out_i : mask_in_i;
    cand_o     = rise & phase_mask;
    eob_rise_o = eob_i & ~eob_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= '0;
      eob_prev_q <= 1'b0;
    end else begin
      req_prev_q <= req_prev_d;
      eob_prev_q <= eob_prev_d;
    end
  end

endmodule

// File: rtl/cta_prio_pick.sv
`timescale 1ns/1ps
module cta_prio_pick #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3,
  parameter int LCNT_W  = 4
) (
  input  logic [NUM_SRC-1:0] cand_i,
  input  logic               block_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic               grant_vld_o,
  output logic [IDX_W-1:0]   grant_idx_o,
  output logic [LCNT_W-1:0]  lose_cnt_o
);

  logic [NUM_SRC-1:0] losers;

  always_comb begin
    grant_o     = '0;
    grant_idx_o = '0;
    grant_vld_o = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!block_i && cand_i[i] && !grant_vld_o) begin
        grant_o[i]  = 1'b1;
        grant_idx_o = IDX_W'(i);
        grant_vld_o = 1'b1;
      end
    end
    losers     = cand_i & ~grant_o;
    lose_cnt_o = LCNT_W'($countones(losers));
  end

endmodule

// File: rtl/cta_delay_line.sv
`timescale 1ns/1ps
module cta_delay_line
  import cta_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SRC_W = 3,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld_i,
  input  trig_kind_e       in_kind_i,
  input  logic [SRC_W-1:0] in_src_i,
  input  logic [SEL_W-1:0] dly_i,
  output logic             out_vld_o,
  output trig_kind_e       out_kind_o,
  output logic [SRC_W-1:0] out_src_o
);

  localparam int TAP_W = $clog2(DEPTH);

  logic             vld_q  [DEPTH];
  trig_kind_e       kind_q [DEPTH];
  logic [SRC_W-1:0] src_q  [DEPTH];
  logic [TAP_W-1:0] tap;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic             vld_d;
    trig_kind_e       kind_d;
    logic [SRC_W-1:0] src_d;
    if (g == 0) begin : g_head
      always_comb begin
        vld_d  = in_vld_i;
        kind_d = in_vld_i ? in_kind_i : TRIG_NONE;
        src_d  = in_vld_i ? in_src_i : '0;
      end
    end else begin : g_body
      always_comb begin
        vld_d  = vld_q[g-1];
        kind_d = kind_q[g-1];
        src_d  = src_q[g-1];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        kind_q[g] <= TRIG_NONE;
        src_q[g]  <= '0;
      end else begin
        vld_q[g]  <= vld_d;
        kind_q[g] <= kind_d;
        src_q[g]  <= src_d;
      end
    end
  end

  always_comb begin
    if (dly_i == '0)                      tap = '0;
    else if (dly_i >= SEL_W'(DEPTH))      tap = TAP_W'(DEPTH - 1);
    else                                  tap = TAP_W'(dly_i - 1'b1);
    out_vld_o  = vld_q[tap];
    out_kind_o = kind_q[tap];
    out_src_o  = src_q[tap];
  end

endmodule

// File: rtl/calib_trig_arbiter.sv
`timescale 1ns/1ps
module calib_trig_arbiter
  import cta_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int MAX_DELAY = 16,
  parameter int CNT_W     = 16,
  localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DLY_W    = $clog2(MAX_DELAY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               end_of_beam_i,
  input  logic [NUM_SRC-1:0] mask_in_burst_i,
  input  logic [NUM_SRC-1:0] mask_out_burst_i,
  input  logic [DLY_W-1:0]   delay_i,
  output logic               trig_valid_o,
  output logic [1:0]         trig_type_o,
  output logic [SRC_W-1:0]   trig_src_o,
  output logic [CNT_W-1:0]   refused_cnt_o
);

  localparam int LCNT_W = $clog2(NUM_SRC + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic [NUM_SRC-1:0] cand;
  logic               ctrl_fire;
  logic [NUM_SRC-1:0] grant;
  logic               grant_vld;
  logic [SRC_W-1:0]   grant_idx;
  logic [LCNT_W-1:0]  lose_cnt;

  cta_req_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_i      (req_i),
    .eob_i      (end_of_beam_i),
    .mask_in_i  (mask_in_burst_i),
    .mask_out_i (mask_out_burst_i),
    .cand_o     (cand),
    .eob_rise_o (ctrl_fire)
  );

  cta_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(SRC_W), .LCNT_W(LCNT_W)) u_pick (
    .cand_i      (cand),
    .block_i     (ctrl_fire),
    .grant_o     (grant),
    .grant_vld_o (grant_vld),
    .grant_idx_o (grant_idx),
    .lose_cnt_o  (lose_cnt)
  );

  // entry slot: control trigger first, then the calibration winner
  logic             in_vld;
  trig_kind_e       in_kind;
  logic [SRC_W-1:0] in_src;
  always_comb begin
    in_vld  = ctrl_fire | grant_vld;
    in_kind = ctrl_fire ? TRIG_CTRL : (grant_vld ? TRIG_CALIB : TRIG_NONE);
    in_src  = ctrl_fire ? '0 : grant_idx;
  end

  trig_kind_e out_kind;
  cta_delay_line #(.DEPTH(MAX_DELAY), .SRC_W(SRC_W), .SEL_W(DLY_W)) u_dly (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .in_vld_i   (in_vld),
    .in_kind_i  (in_kind),
    .in_src_i   (in_src),
    .dly_i      (delay_i),
    .out_vld_o  (trig_valid_o),
    .out_kind_o (out_kind),
    .out_src_o  (trig_src_o)
  );
  assign trig_type_o = out_kind;

  // saturating refusal counter
  logic [CNT_W:0]   cnt_sum;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  always_comb begin
    cnt_sum = {1'b0, cnt_q} + (CNT_W+1)'(lose_cnt);
    cnt_d   = cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
    cnt_en  = (lose_cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
  assign refused_cnt_o = cnt_q;

endmodule

// File: rtl/cta_checker.sv
`timescale 1ns/1ps
module cta_checker #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               eob,
  input logic [NUM_SRC-1:0] mask_in,
  input logic [NUM_SRC-1:0] mask_out,
  input logic [NUM_SRC-1:0] grant,
  input logic [1:0]         head_kind,
  input logic               trig_valid,
  input logic [1:0]         trig_type,
  input logic [SRC_W-1:0]   trig_src,
  input logic [CNT_W-1:0]   cnt
);

  assert_type_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_valid |-> trig_type == 2'b00);

  assert_type_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> (trig_type == 2'b01 || trig_type == 2'b10));

  assert_ctrl_src_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_type == 2'b10) |-> trig_src == '0);

  assert_single_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_mask_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eob |-> (grant & ~mask_in) == '0);

  assert_mask_out_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eob |-> (grant & ~mask_out) == '0);

  assert_ctrl_precedence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eob) |-> grant == '0);

  assert_ctrl_enters_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eob) |=> head_kind == 2'b10);

  assert_cnt_no_decrease_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= $past(cnt));

endmodule

bind calib_trig_arbiter cta_checker #(
  .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CNT_W(CNT_W)
) u_cta_checker (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .eob        (end_of_beam_i),
  .mask_in    (mask_in_burst_i),
  .mask_out   (mask_out_burst_i),
  .grant      (grant),
  .head_kind  (u_dly.kind_q[0]),
  .trig_valid (trig_valid_o),
  .trig_type  (trig_type_o),
  .trig_src   (trig_src_o),
  .cnt        (refused_cnt_o)
);

// File: tb/calib_trig_arbiter_bench.sv
`timescale 1ns/1ps
module calib_trig_arbiter_bench;

  localparam int NS = 8;
  localparam int MD = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] req;
  logic          eob;
  logic [NS-1:0] m_in, m_out;
  logic [4:0]    dly;
  logic          t_vld;
  logic [1:0]    t_type;
  logic [2:0]    t_src;
  logic [CW-1:0] cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  calib_trig_arbiter #(.NUM_SRC(NS), .MAX_DELAY(MD), .CNT_W(CW)) u_calib_trig_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .end_of_beam_i(eob),
    .mask_in_burst_i(m_in), .mask_out_burst_i(m_out), .delay_i(dly),
    .trig_valid_o(t_vld), .trig_type_o(t_type), .trig_src_o(t_src),
    .refused_cnt_o(cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pulse the inputs for one cycle, then watch 24 cycles for the first trigger
  task automatic fire(input logic [NS-1:0] r, input logic e,
                      output int lat, output logic [1:0] ty, output logic [2:0] sr);
    @(negedge clk);
    req = r; eob = e; lat = 0; ty = 2'b00; sr = 3'd0;
    for (int n = 1; n <= 24; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 1) req = '0;
      if (t_vld && lat == 0) begin
        lat = n; ty = t_type; sr = t_src;
      end
    end
  endtask

  typedef struct packed {
    logic [7:0] req;
    logic       eob;
    logic       vld;
    logic [1:0] ty;
    logic [2:0] src;
    logic [7:0] cnt;
  } vec_t;

  // masks: in-burst 8'h0F, out-of-burst 8'hF0, delay 3
  localparam vec_t TABLE [14] = '{
    '{8'h01, 1'b0, 1'b1, 2'b01, 3'd0, 8'd0},  // R3 src0 allowed in-burst
    '{8'h08, 1'b0, 1'b1, 2'b01, 3'd3, 8'd0},  // R3 src3
    '{8'h10, 1'b0, 1'b0, 2'b00, 3'd0, 8'd0},  // R3 src4 masked in-burst
    '{8'h06, 1'b0, 1'b1, 2'b01, 3'd1, 8'd1},  // R5 src1 beats src2
    '{8'h0C, 1'b0, 1'b1, 2'b01, 3'd2, 8'd2},  // R5 src2 beats src3
    '{8'h00, 1'b1, 1'b1, 2'b10, 3'd0, 8'd2},  // R7 control on end-of-beam rise
    '{8'h10, 1'b1, 1'b1, 2'b01, 3'd4, 8'd2},  // R4 src4 allowed out-of-burst
    '{8'h01, 1'b1, 1'b0, 2'b00, 3'd0, 8'd2},  // R4 src0 masked out-of-burst
    '{8'hA0, 1'b1, 1'b1, 2'b01, 3'd5, 8'd3},  // R5 R8 src5 beats src7
    '{8'h30, 1'b0, 1'b0, 2'b00, 3'd0, 8'd3},  // R3 back in-burst, both masked
    '{8'h02, 1'b1, 1'b1, 2'b10, 3'd0, 8'd3},  // R7 R8 masked loser not counted
    '{8'h00, 1'b0, 1'b0, 2'b00, 3'd0, 8'd3},  // R7 fall gives nothing
    '{8'h10, 1'b1, 1'b1, 2'b10, 3'd0, 8'd4},  // R7 R8 control wins, eligible loser counted
    '{8'h00, 1'b1, 1'b0, 2'b00, 3'd0, 8'd4}   // R7 no repeat while level held
  };

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [1:0] ty;
    logic [2:0] sr;
    int seen;

    rst_n = 1'b0; req = '0; eob = 1'b0;
    m_in = 8'h0F; m_out = 8'hF0; dly = 5'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!t_vld && t_type == 2'b00, "R1 idle in reset", t_vld, 0);
    chk(cnt == 0, "R1 counter in reset", cnt, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!t_vld && cnt == 0, "R1 idle after release", t_vld, 0);

    foreach (TABLE[i]) begin
      fire(TABLE[i].req, TABLE[i].eob, lat, ty, sr);
      if (TABLE[i].vld) begin
        chk(lat == 3, $sformatf("R6 vec%0d latency", i), lat, 3);
        chk(ty == TABLE[i].ty, $sformatf("R9 vec%0d type", i), ty, TABLE[i].ty);
        chk(sr == TABLE[i].src, $sformatf("R5 vec%0d source", i), sr, TABLE[i].src);
      end else begin
        chk(lat == 0, $sformatf("R3 R4 vec%0d no trigger", i), lat, 0);
      end
      chk(cnt == TABLE[i].cnt, $sformatf("R8 vec%0d refused count", i), cnt, TABLE[i].cnt);
    end

    // R2: a held request yields one trigger
    @(negedge clk); eob = 1'b0;
    repeat (3) @(negedge clk);
    req = 8'h01; seen = 0;
    for (int n = 0; n < 20; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == 8) req = '0;
      if (t_vld) seen++;
    end
    chk(seen == 1, "R2 held request single trigger", seen, 1);

    // R6: delay settings and clamps
    dly = 5'd1;  fire(8'h02, 1'b0, lat, ty, sr);
    chk(lat == 1, "R6 delay 1", lat, 1);
    dly = 5'd0;  fire(8'h02, 1'b0, lat, ty, sr);
    chk(lat == 1, "R6 delay 0 acts as 1", lat, 1);
    dly = 5'd16; fire(8'h02, 1'b0, lat, ty, sr);
    chk(lat == 16, "R6 delay 16", lat, 16);
    dly = 5'd20; fire(8'h02, 1'b0, lat, ty, sr);
    chk(lat == 16, "R6 delay 20 clamps to 16", lat, 16);
    chk(sr == 3'd1 && ty == 2'b01, "R9 calibration word", sr, 1);

    // R8: saturation, seven losers per pulse
    dly = 5'd2; m_in = 8'hFF;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk); req = 8'hFF;
      @(negedge clk); req = '0;
    end
    repeat (4) @(negedge clk);
    chk(cnt == 8'hFF, "R8 counter saturates", cnt, 255);

    // R1: reset drops an in-flight trigger and clears the counter
    dly = 5'd8;
    @(negedge clk); req = 8'h01;
    @(negedge clk); req = '0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(cnt == 0, "R1 counter cleared by reset", cnt, 0);
    rst_n = 1'b1;
    seen = 0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (t_vld) seen++;
    end
    chk(seen == 0, "R1 in-flight trigger dropped", seen, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule